// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter (I2S master)

This block turns pairs of signed PCM samples into an I2S stream and acts as the bus master. It runs from one master clock at 256 times the sample rate. From that clock it makes the bit clock and the word-select clock, and it shifts one left/right pair per frame onto a single data line. With the default 16-bit samples a frame holds 32 bit clocks, so the bit clock is the master clock divided by eight.

Samples arrive on a parallel port with a valid/ready handshake. Ready is high for exactly one master-clock cycle, at the very end of each frame. A pair offered in that cycle is loaded and sent in the next frame. In a frame where no pair was offered, the data line carries zeros. The frame counter starts at slot 0 when reset is released, so the first frame after reset is always silent.

The sample width and the master-clock count per frame are parameters. The bit-clock divider is derived from them.

Top module: `i2s_tx_master`

## Requirements
- R1: While synchronous active-high reset is applied, and in the cycle after it is released, `sck_o`, `ws_o`, `sd_o` and `ready_o` are all 0.
- R2: `sck_o` has a period of 8 master clocks (MCLK_PER_FRAME / (2·SAMPLE_W)). After reset it is low for master-clock edges 1–3, goes high on edge 4 and falls again on edge 8, and the pattern repeats from there.
- R3: `ws_o` has a 50% duty cycle and holds each level for 16 bit-clock periods. It changes only in the master-clock cycle in which `sck_o` falls. Counting bit slots 0–31 from the start of a frame, it is high during slots 15–30 and low during slots 31 and 0–14.
- R4: `sd_o` changes only in the master-clock cycle in which `sck_o` falls.
- R5: The left word is sent while `ws_o` is low and the right word while `ws_o` is high. A word's MSB comes one bit-clock period after the `ws_o` transition, and its LSB is driven in the slot in which `ws_o` changes. The left word fills slots 0–15 and the right word fills slots 16–31.
- R6: Each word is sent MSB first, as the two's-complement bits of the sample, with no change to the value.
- R7: `ready_o` is high for exactly one master-clock cycle per frame, the last one: slot 31, while `sck_o` is high. `valid_i` and the sample inputs are ignored in every other cycle.
- R8: If `valid_i` is low while `ready_o` is high, the whole next frame carries `sd_o` = 0.
- R9: The first frame after reset carries `sd_o` = 0 in every slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock, 256 × sample rate |
| rst_i | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | A sample pair is offered |
| left_i | input | SAMPLE_W | Left sample, two's complement |
| right_i | input | SAMPLE_W | Right sample, two's complement |
| ready_o | output | 1 | Last cycle of a frame; a pair is taken when valid_i is also high |
| sck_o | output | 1 | Bit clock |
| ws_o | output | 1 | Word select: 0 = left, 1 = right |
| sd_o | output | 1 | Serial data |

## Verification
The assertions assume reset is held from time zero until at least one master-clock edge has passed. They also assume the inputs are driven from the master-clock domain, so a pair seen with `ready_o` high is stable at the edge that loads it. The bench changes every input half a cycle away from the active edge. It also keeps asserting `valid_i` with junk data outside the ready cycle, so any leak through the handshake shows up on the data line. Across forty frames it switches between sent pairs and silent frames.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

    localparam int unsigned DEF_SAMPLE_W       = 16;
    localparam int unsigned DEF_MCLK_PER_FRAME = 256;

    // Level of the word-select line; it also names the channel being sent.
    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } chan_e;

    // Word-select level during a bit slot. It leads the data by one slot,
    // so it turns over in the slot that carries the previous word's LSB.
    function automatic chan_e ws_for_slot(input int unsigned slot, input int unsigned sw);
        return (((slot + 1) % (2 * sw)) >= sw) ? CH_RIGHT : CH_LEFT;
    endfunction

endpackage

// File: rtl/i2s_tx_timing.sv
module i2s_tx_timing
    import i2s_tx_pkg::*;
#(
    parameter int unsigned SAMPLE_W       = DEF_SAMPLE_W,
    parameter int unsigned MCLK_PER_FRAME = DEF_MCLK_PER_FRAME
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic sck_o,
    output logic ws_o,
    output logic fall_o,
    output logic frame_end_o
);
    localparam int unsigned FRAME_BITS = 2 * SAMPLE_W;
    localparam int unsigned DIV        = MCLK_PER_FRAME / FRAME_BITS;
    localparam int unsigned HALF       = DIV / 2;
    localparam int unsigned DW         = (DIV > 1) ? $clog2(DIV) : 1;
    localparam int unsigned SLW        = $clog2(FRAME_BITS);

    logic [DW-1:0]  div_q;
    logic [SLW-1:0] slot_q;
    logic [SLW-1:0] slot_nx;
    logic           sck_q;
    chan_e          ws_q;
    logic           div_last;

    assign div_last = (div_q == DW'(DIV - 1));
    assign slot_nx  = (slot_q == SLW'(FRAME_BITS - 1)) ? '0 : slot_q + 1'b1;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            div_q  <= '0;
            slot_q <= '0;
            sck_q  <= 1'b0;
            ws_q   <= CH_LEFT;
        end else begin
            div_q <= div_last ? '0 : div_q + 1'b1;
            if (div_q == DW'(HALF - 1)) begin
                sck_q <= 1'b1;
            end
            if (div_last) begin
                sck_q  <= 1'b0;
                slot_q <= slot_nx;
                ws_q   <= ws_for_slot(int'(slot_nx), SAMPLE_W);
            end
        end
    end

    assign sck_o       = sck_q;
    assign ws_o        = ws_q;
    assign fall_o      = div_last;
    assign frame_end_o = div_last && (slot_q == SLW'(FRAME_BITS - 1));

    AST_WS_ON_FALL: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(ws_q) |-> $fell(sck_q)); // R3
    AST_SCK_RISE_MID: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(sck_q) |-> (div_q == DW'(HALF))); // R2

endmodule

// File: rtl/i2s_tx_shifter.sv
module i2s_tx_shifter
    import i2s_tx_pkg::*;
#(
    parameter int unsigned SAMPLE_W = DEF_SAMPLE_W
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                shift_i,
    input  logic                load_i,
    input  logic                take_i,
    input  logic [SAMPLE_W-1:0] left_i,
    input  logic [SAMPLE_W-1:0] right_i,
    output logic                sd_o
);
    localparam int unsigned FW = 2 * SAMPLE_W;

    logic [FW-1:0] sh_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sh_q <= '0;
        end else if (shift_i) begin
            if (load_i) begin
                sh_q <= take_i ? {left_i, right_i} : '0;
            end else begin
                sh_q <= {sh_q[FW-2:0], 1'b0};
            end
        end
    end

    assign sd_o = sh_q[FW-1];

    AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        (shift_i && load_i && !take_i) |=> !sd_o); // R8
    AST_LOAD_MSB: assert property (@(posedge clk_i) disable iff (rst_i)
        (shift_i && load_i && take_i) |=> (sd_o == $past(left_i[SAMPLE_W-1]))); // R6

endmodule

// File: rtl/i2s_tx_master.sv
module i2s_tx_master
    import i2s_tx_pkg::*;
#(
    parameter int unsigned SAMPLE_W       = DEF_SAMPLE_W,
    parameter int unsigned MCLK_PER_FRAME = DEF_MCLK_PER_FRAME
) (
    input  logic                       clk_i,
    input  logic                       rst_i,
    input  logic                       valid_i,
    input  logic signed [SAMPLE_W-1:0] left_i,
    input  logic signed [SAMPLE_W-1:0] right_i,
    output logic                       ready_o,
    output logic                       sck_o,
    output logic                       ws_o,
    output logic                       sd_o
);
    logic fall;
    logic frame_end;

    i2s_tx_timing #(
        .SAMPLE_W       (SAMPLE_W),
        .MCLK_PER_FRAME (MCLK_PER_FRAME)
    ) u_timing (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .sck_o       (sck_o),
        .ws_o        (ws_o),
        .fall_o      (fall),
        .frame_end_o (frame_end)
    );

    i2s_tx_shifter #(
        .SAMPLE_W (SAMPLE_W)
    ) u_shifter (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .shift_i (fall),
        .load_i  (frame_end),
        .take_i  (valid_i),
        .left_i  (left_i),
        .right_i (right_i),
        .sd_o    (sd_o)
    );

    assign ready_o = frame_end;

    AST_SD_ON_FALL: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(sd_o) |-> $fell(sck_o)); // R4
    AST_READY_PHASE: assert property (@(posedge clk_i) disable iff (rst_i)
        ready_o |-> (sck_o && !ws_o)); // R7
    AST_READY_THEN_LEFT: assert property (@(posedge clk_i) disable iff (rst_i)
        ready_o |=> ($fell(sck_o) && !ws_o && !ready_o)); // R5

endmodule

// File: tb/tb_i2s_tx_master.sv
module tb_i2s_tx_master;
    localparam int SW  = 16;
    localparam int FB  = 2 * SW;
    localparam int FMC = 256;
    localparam int DIV = FMC / FB;
    localparam int NF  = 40;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 valid = 1'b0;
    logic signed [SW-1:0] left = '0;
    logic signed [SW-1:0] right = '0;
    logic                 ready, sck, ws, sd;

    always #4 clk = ~clk;

    i2s_tx_master #(.SAMPLE_W(SW), .MCLK_PER_FRAME(FMC)) dut (
        .clk_i   (clk),
        .rst_i   (rst),
        .valid_i (valid),
        .left_i  (left),
        .right_i (right),
        .ready_o (ready),
        .sck_o   (sck),
        .ws_o    (ws),
        .sd_o    (sd)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    logic [SW-1:0] pl [0:NF+1];
    logic [SW-1:0] pr [0:NF+1];

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: got %0b expected %0b", tag, what, act, exp);
        end
    endtask

    function automatic bit use_frame(input int f);
        return (f % 5) != 0;
    endfunction

    function automatic logic [SW-1:0] gen_word(input int f, input bit rch);
        logic [31:0] h;
        case (f)
            1: return rch ? 16'h8000 : 16'h7FFF;
            2: return rch ? 16'h0001 : 16'hFFFF;
            3: return rch ? 16'h5555 : 16'hAAAA;
            4: return rch ? 16'hFFFE : 16'h0001;
            6: return rch ? 16'h8001 : 16'hFF00;
            default: begin
                h = (f * 32'h9E3779B1) ^ (rch ? 32'h0123_4567 : 32'h89AB_CDEF);
                return h[31:16];
            end
        endcase
    endfunction

    initial begin
        logic prev_sd, prev_sck, rx_ws, bitv, exp_sd;
        logic [SW-1:0] acc, word;
        int f, s, nf;
        string sd_tag;
        for (int i = 0; i <= NF + 1; i++) begin
            pl[i] = '0;
            pr[i] = '0;
        end
        repeat (3) @(negedge clk);
        // R1: outputs while still in reset
        chk("R1", "sck in reset", sck, 1'b0);
        chk("R1", "ws in reset", ws, 1'b0);
        chk("R1", "sd in reset", sd, 1'b0);
        chk("R1", "ready in reset", ready, 1'b0);
        rst = 1'b0;
        chk("R1", "sck after release", sck, 1'b0);
        chk("R1", "ready after release", ready, 1'b0);
        prev_sd = 1'b0; prev_sck = 1'b0; rx_ws = 1'b0; acc = '0;
        for (int k = 0; k < NF * FMC; k++) begin
            f = k / FMC;
            s = (k / DIV) % FB;
            exp_sd = (s < SW) ? pl[f][SW-1-s] : pr[f][FB-1-s];
            sd_tag = (f == 0) ? "R9" : (use_frame(f) ? "R6" : "R8");
            chk("R2", "sck", sck, ((k % DIV) >= DIV / 2) ? 1'b1 : 1'b0);
            chk("R3", "ws", ws, (s >= SW - 1 && s <= FB - 2) ? 1'b1 : 1'b0);
            chk(sd_tag, "sd", sd, exp_sd);
            chk("R7", "ready", ready, (k % FMC == FMC - 1) ? 1'b1 : 1'b0);
            if (k > 0 && sd !== prev_sd) begin
                // R4: a change on the data line must sit on a bit-clock fall
                chk("R4", "sd change off falling edge", ((k % DIV) == 0) ? 1'b1 : 1'b0, 1'b1);
            end
            prev_sd = sd;
            // R5: receiver model sampling on the bit-clock rising edge
            if (sck === 1'b1 && prev_sck === 1'b0) begin
                bitv = sd;
                if (ws !== rx_ws) begin
                    word = {acc[SW-2:0], bitv};
                    total++;
                    if (word !== (rx_ws ? pr[f] : pl[f])) begin
                        bad++;
                        $display("FAIL R5 %s word frame %0d: got %h expected %h",
                                 rx_ws ? "right" : "left", f, word, rx_ws ? pr[f] : pl[f]);
                    end
                    acc = '0;
                    rx_ws = ws;
                end else begin
                    acc = {acc[SW-2:0], bitv};
                end
            end
            prev_sck = sck;
            if (k % FMC == FMC - 1) begin
                nf = f + 1;
                valid = use_frame(nf);
                left  = gen_word(nf, 1'b0);
                right = gen_word(nf, 1'b1);
                if (use_frame(nf)) begin
                    pl[nf] = left;
                    pr[nf] = right;
                end
            end else begin
                // R7: junk offered outside the ready cycle must be ignored
                valid = (k % 3) == 0;
                left  = SW'(k * 7 + 3);
                right = ~SW'(k * 5);
            end
            @(posedge clk);
            @(negedge clk);
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got running expected finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule